// File: doc/BRIEF.md
# Synchronous Slave Serial Receiver

This block takes in serial words from an external master that drives both the bit clock and the data line. The external clock and data are brought into the system clock domain through a chain of synchronising flops. On each chosen edge of the synchronised clock the block captures one data bit, least significant bit first, into a shift register. A word is either 8 or 9 bits long. When the last bit arrives, the word is copied into a holding register and a receive-complete flag is raised. An interrupt output follows that flag when the interrupt enable is set.

A small register-style host port holds a control byte and a status byte, and gives read access to the received data. Reading the data register clears the receive-complete flag. If a word completes while the flag is still set, that word is dropped and a sticky overrun bit is set. After an overrun, no further word reaches the holding register until the continuous-receive enable is cleared and set again. Clearing that enable is the only way to clear errors, and it also discards any word that is only partly received. In 9-bit mode the ninth bit is reported in the status register, and the data register holds the low eight bits.

Top module: `ssr_rx`

## Requirements
- R1: A word is received only when control bits 0 (port enable), 1 (synchronous mode) and 3 (continuous receive) are all 1 and bit 2 (clock-source master) is 0. In every other combination of these four bits, no word completes and the flag stays 0.
- R2: Control bit 4 (single-receive request) has no effect. Reception follows R1 whether this bit is 0 or 1.
- R3: Data bits are captured LSB first, one per rising edge of the synchronised external clock.
- R4: When control bit 5 is 0, each word is 8 bits long. On completion, the word appears at address 2 (data) and status bit 3 (receive complete) becomes 1.
- R5: When control bit 5 is 1, each word is 9 bits long. The low 8 bits appear at address 2 and the ninth bit appears in status bit 0.
- R6: The output irq is 1 exactly when status bit 3 is 1 and control bit 6 (interrupt enable) is 1.
- R7: A host read of address 2 clears status bit 3.
- R8: A word that completes while status bit 3 is 1 is discarded. Status bit 2 (overrun) becomes 1 and the data register keeps its old value.
- R9: While status bit 2 is 1, completed words are not transferred and status bit 3 stays 0, even after the flag has been cleared.
- R10: Clearing control bit 3 clears status bit 2 and abandons any partly received word. The next word is assembled from its own bits only.
- R11: The status byte at address 1 has bit 1 (framing error) always 0 in synchronous operation, and bits 7:4 are 0.
- R12: After reset, control, data and status all read 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_sck | input | 1 | Bit clock from the external master |
| ext_sdat | input | 1 | Serial data from the external master |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write address (0 = control) |
| wr_data | input | 8 | Host write data |
| rd_en | input | 1 | Host read strobe (a read of address 2 clears the flag) |
| rd_addr | input | 2 | Host read address (0 control, 1 status, 2 data) |
| rd_data | output | 8 | Host read data |
| irq | output | 1 | Receive interrupt |

## Verification
The bench builds the block with its default parameters: 8 data bits, a two-stage synchroniser and rising-edge sampling. At this size every 8-bit value and every 9-bit value can be sent through the receiver in one run, so both word lengths are swept in full. All sixteen combinations of the four enable bits are also stepped through. With these small widths, the overrun, lockout and partial-word abandonment sequences are short enough to be followed bit by bit.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
   localparam int unsigned REG_ADDR_W = 2;

   typedef enum logic [REG_ADDR_W-1:0] {
      ADDR_CTRL   = 2'd0,
      ADDR_STATUS = 2'd1,
      ADDR_DATA   = 2'd2
   } reg_addr_e;

   typedef struct packed {
      logic spare;
      logic irq_en;
      logic nine_bit;
      logic single_req;
      logic cont_rx;
      logic master_sel;
      logic sync_mode;
      logic port_en;
   } ctrl_t;
endpackage

// File: rtl/ssr_edge_sync.sv
module ssr_edge_sync #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SAMPLE_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_async,
   input  logic sdat_async,
   output logic sample_stb,
   output logic sdat_sync
);
   initial begin
      if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES:0]   sck_pipe;
   logic [SYNC_STAGES-1:0] dat_pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_pipe <= '0;
         dat_pipe <= '0;
      end else begin
         sck_pipe <= {sck_pipe[SYNC_STAGES-1:0], sck_async};
         dat_pipe <= {dat_pipe[SYNC_STAGES-2:0], sdat_async};
      end
   end

   assign sdat_sync = dat_pipe[SYNC_STAGES-1];

   generate
      if (SAMPLE_RISE) begin : g_rise
         assign sample_stb = sck_pipe[SYNC_STAGES-1] & ~sck_pipe[SYNC_STAGES];
      end else begin : g_fall
         assign sample_stb = ~sck_pipe[SYNC_STAGES-1] & sck_pipe[SYNC_STAGES];
      end
   endgenerate
endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter #(
   parameter int unsigned WORD_MAX = 9,
   localparam int unsigned CNT_W  = $clog2(WORD_MAX + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                active,
   input  logic                sample_stb,
   input  logic                din,
   input  logic                long_word,
   output logic                done,
   output logic [WORD_MAX-1:0] word
);
   initial begin
      if (WORD_MAX < 3) $error("WORD_MAX too small");
   end

   logic [CNT_W-1:0]    cnt;
   logic [WORD_MAX-1:0] sr, sr_nxt;
   logic [CNT_W-1:0]    last_idx;

   assign last_idx = long_word ? CNT_W'(WORD_MAX - 1) : CNT_W'(WORD_MAX - 2);

   always_comb begin
      sr_nxt = sr;
      for (int i = 0; i < WORD_MAX; i++) begin
         if (cnt == CNT_W'(i)) sr_nxt[i] = din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         sr   <= '0;
         done <= 1'b0;
         word <= '0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            cnt <= '0;
            sr  <= '0;
         end else if (sample_stb) begin
            if (cnt >= last_idx) begin
               word <= long_word ? sr_nxt : {1'b0, sr_nxt[WORD_MAX-2:0]};
               done <= 1'b1;
               cnt  <= '0;
               sr   <= '0;
            end else begin
               sr  <= sr_nxt;
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R10
   idle_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (cnt == '0));
   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CNT_W'(WORD_MAX));
   // R1
   done_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(active));
endmodule

// File: rtl/ssr_regs.sv
module ssr_regs
   import ssr_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   localparam int unsigned WORD_MAX = DATA_W + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  rd_en,
   input  logic [REG_ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0]     rd_data,
   input  logic                  done,
   input  logic [WORD_MAX-1:0]   word,
   output logic                  rx_active,
   output logic                  long_word,
   output logic                  irq
);
   initial begin
      if (DATA_W != 8) $error("control byte layout assumes DATA_W == 8");
   end

   ctrl_t             ctrl;
   logic [DATA_W-1:0] hold;
   logic              ninth, full, ovr;
   logic              data_rd;

   assign rx_active = ctrl.port_en & ctrl.sync_mode & ~ctrl.master_sel & ctrl.cont_rx;
   assign long_word = ctrl.nine_bit;
   assign data_rd   = rd_en && (rd_addr == ADDR_DATA);
   assign irq       = full & ctrl.irq_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl <= '0;
      else if (wr_en && wr_addr == ADDR_CTRL) ctrl <= ctrl_t'(wr_data);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold  <= '0;
         ninth <= 1'b0;
         full  <= 1'b0;
         ovr   <= 1'b0;
      end else begin
         if (data_rd) full <= 1'b0;
         if (!ctrl.cont_rx) ovr <= 1'b0;
         else if (done) begin
            if (full) ovr <= 1'b1;
            else if (!ovr) begin
               hold  <= word[DATA_W-1:0];
               ninth <= word[DATA_W];
               full  <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      unique case (rd_addr)
         ADDR_CTRL:   rd_data = ctrl;
         ADDR_STATUS: rd_data = {4'b0, full, ovr, 1'b0, ninth};
         ADDR_DATA:   rd_data = hold;
         default:     rd_data = '0;
      endcase
   end

   // R8
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && ctrl.cont_rx) |=> ovr);
   // R9
   ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |=> $stable(hold));
   // R10
   ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.cont_rx |=> !ovr);
   // R7
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !done) |=> !full);
   // R6
   irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(full) && ctrl.irq_en) |-> irq);
endmodule

// File: rtl/ssr_rx.sv
module ssr_rx
   import ssr_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SAMPLE_RISE = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ext_sck,
   input  logic        ext_sdat,
   input  logic        wr_en,
   input  logic [1:0]  wr_addr,
   input  logic [7:0]  wr_data,
   input  logic        rd_en,
   input  logic [1:0]  rd_addr,
   output logic [7:0]  rd_data,
   output logic        irq
);
   localparam int unsigned WORD_MAX = DATA_W + 1;

   logic                sample_stb, sdat_sync;
   logic                rx_active, long_word, done;
   logic [WORD_MAX-1:0] word;

   ssr_edge_sync #(.SYNC_STAGES(SYNC_STAGES), .SAMPLE_RISE(SAMPLE_RISE)) u_sync (
      .clk(clk), .rst_n(rst_n), .sck_async(ext_sck), .sdat_async(ext_sdat),
      .sample_stb(sample_stb), .sdat_sync(sdat_sync));

   ssr_shifter #(.WORD_MAX(WORD_MAX)) u_shift (
      .clk(clk), .rst_n(rst_n), .active(rx_active), .sample_stb(sample_stb),
      .din(sdat_sync), .long_word(long_word), .done(done), .word(word));

   ssr_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .done(done), .word(word), .rx_active(rx_active), .long_word(long_word),
      .irq(irq));
endmodule

// File: tb/ssr_rx_tb.sv
module ssr_rx_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_sck = 1'b0, ext_sdat = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0] wr_addr = '0, rd_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       irq;
   int         n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   ssr_rx u_dut (.clk(clk), .rst_n(rst_n), .ext_sck(ext_sck), .ext_sdat(ext_sdat),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_ctrl(input logic [7:0] v);
      @(negedge clk); wr_en = 1'b1; wr_addr = 2'd0; wr_data = v;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk); rd_en = 1'b1; rd_addr = a; #1 v = rd_data;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic send(input logic [8:0] val, input int nb);
      for (int i = 0; i < nb; i++) begin
         @(negedge clk); ext_sdat = val[i];
         repeat (3) @(negedge clk);
         ext_sck = 1'b1;
         repeat (4) @(negedge clk);
         ext_sck = 1'b0;
         repeat (3) @(negedge clk);
      end
      repeat (6) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] v, st;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R12 reset state
      rd(2'd0, v); chk("R12 ctrl", v, 0);
      rd(2'd1, v); chk("R12 status", v, 0);
      rd(2'd2, v); chk("R12 data", v, 0);
      chk("R12 irq", irq, 0);

      // R1 and R2: every enable combination, with single request both ways
      for (int c = 0; c < 16; c++) begin
         for (int s = 0; s < 2; s++) begin
            logic [7:0] cv;
            cv = {3'b0, s[0], c[3:0]};
            wr_ctrl(8'h00);
            wr_ctrl(cv);
            send(9'h0A5, 8);
            rd(2'd1, st);
            chk(c == 4'b1011 ? "R2 enabled word" : "R1 disabled combo",
                st[3], (c == 4'b1011) ? 1 : 0);
            rd(2'd2, v);
            if (c == 4'b1011) chk("R1 data", v, 8'hA5);
         end
      end

      // R3 R4 exhaustive 8-bit sweep
      wr_ctrl(8'h00); wr_ctrl(8'h0B);
      for (int d = 0; d < 256; d++) begin
         send(9'(d), 8);
         rd(2'd1, st); chk("R4 flag", st[3], 1);
         rd(2'd2, v);  chk("R3 data lsb first", v, d);
         rd(2'd1, st); chk("R7 flag cleared", st[3], 0);
      end

      // R5 exhaustive 9-bit sweep
      wr_ctrl(8'h00); wr_ctrl(8'h2B);
      for (int d = 0; d < 512; d++) begin
         send(9'(d), 9);
         rd(2'd1, st); chk("R5 ninth bit", st[0], d >> 8);
         chk("R11 framing/upper", {st[7:4], st[1]}, 0);
         rd(2'd2, v);  chk("R5 low byte", v, d & 255);
      end

      // R6 interrupt
      wr_ctrl(8'h00); wr_ctrl(8'h4B);
      chk("R6 irq idle", irq, 0);
      send(9'h03C, 8);
      chk("R6 irq set", irq, 1);
      rd(2'd2, v);
      chk("R6 irq after read", irq, 0);
      send(9'h03D, 8);
      wr_ctrl(8'h0B);
      chk("R6 irq masked", irq, 0);
      rd(2'd2, v); chk("R6 masked data", v, 8'h3D);

      // R8 overrun
      send(9'h011, 8);
      send(9'h022, 8);
      rd(2'd1, st); chk("R8 overrun set", st[2], 1);
      rd(2'd2, v);  chk("R8 old data kept", v, 8'h11);
      // R9 lockout
      send(9'h033, 8);
      rd(2'd1, st); chk("R9 no flag", st[3], 0);
      chk("R9 overrun stays", st[2], 1);
      rd(2'd2, v);  chk("R9 data unchanged", v, 8'h11);
      // R10 clear by continuous-receive enable
      wr_ctrl(8'h03);
      rd(2'd1, st); chk("R10 overrun cleared", st[2], 0);
      wr_ctrl(8'h0B);
      send(9'h1FF, 3);
      wr_ctrl(8'h03);
      wr_ctrl(8'h0B);
      send(9'h040, 8);
      rd(2'd1, st); chk("R10 flag", st[3], 1);
      rd(2'd2, v);  chk("R10 partial abandoned", v, 8'h40);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule